// File: doc/BRIEF.md
# Universal Iterative CORDIC Engine

This block is a sequential fixed-point CORDIC unit. It takes a signed (X, Y, Z) triple, a coordinate-system selection and a direction flag. It then runs a fixed series of shift-and-add micro-rotations, one per clock, and leaves the updated triple in its output registers. Circular, linear and hyperbolic systems all share one datapath. In each system, rotation drives Z toward zero and vectoring drives Y toward zero.

A caller pulses `start` while the engine is idle and the operands are held valid. `busy` then stays high while the iterations run, and `done` pulses for one cycle when the result is ready. The engine does not correct for the processing gain. Callers pre-scale their operands, for example by loading X = 1/K for circular rotation. Callers also keep operands inside the convergence range, because the engine does no quadrant folding or range extension.

Top module: `cordic_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0 and all three result outputs are 0.
- R2: All operands and results are 16-bit two's-complement Q2.14 values. A `start` sampled high while `busy` is 0 loads the operands, `coord` and `vectoring`, and `busy` is 1 on the following cycle.
- R3: In the circular and linear systems, iterations use shift indices 0 through 13. `done` is high exactly 14 clock cycles after the accepting edge, and `busy` is 0 in that cycle.
- R4: Circular rotation (`coord`=2'b00, `vectoring`=0) applies X' = X - d*(Y>>>i), Y' = Y + d*(X>>>i), Z' = Z - d*atan(2^-i) with d = +1 when Z >= 0 and d = -1 otherwise. All additions wrap to 16 bits.
- R5: Circular vectoring (`vectoring`=1) uses the same updates with d = +1 when Y < 0 and d = -1 otherwise.
- R6: Linear operation (`coord`=2'b01) leaves X unchanged, uses Y' = Y + d*(X>>>i) and Z' = Z - d*2^-i, and chooses d by the same rule as the circular system for the selected direction.
- R7: Hyperbolic operation (`coord`=2'b10) uses X' = X + d*(Y>>>i), with Y and Z updated as in R4 but with atanh(2^-i). The indices run 1,2,3,4,4,5,...,13,13, which is 15 steps, and `done` is high 15 cycles after the accepting edge.
- R8: A Z of zero in rotation counts as non-negative, so d = +1. A Y of zero in vectoring counts as non-negative, so d = -1.
- R9: Each angle constant is its real value times 2^14, rounded to the nearest integer. For example, atan(1) is 12868, atanh(1/2) is 9000, and the linear step 2^0 is 16384.
- R10: A `start` that arrives while `busy` is 1 is ignored. It does not change the running operation, its result or its timing, and it produces no extra `done`.
- R11: `done` lasts exactly one cycle. The outputs keep their values from the `done` cycle until the next accepted `start`.
- R12: `coord`=2'b11 behaves exactly as circular operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| vectoring | input | 1 | 0 = rotation (Z toward 0), 1 = vectoring (Y toward 0) |
| coord | input | 2 | 00 circular, 01 linear, 10 hyperbolic, 11 circular |
| x_in | input | 16 | X operand, Q2.14 |
| y_in | input | 16 | Y operand, Q2.14 |
| z_in | input | 16 | Z operand, Q2.14 |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle result-ready pulse |
| x_out | output | 16 | X result, Q2.14 |
| y_out | output | 16 | Y result, Q2.14 |
| z_out | output | 16 | Z result, Q2.14 |

## Verification
The bench drives random operands in each of the six system and direction pairs and compares the results bit for bit with a step model. That model takes its angle constants from real-valued arctangent and logarithm functions. It would therefore catch a wrong table entry, a wrong sign rule or a swapped X update.

Several directed cases use known physical results within a tolerance: cos/sin of 30 degrees, the magnitude and angle of (0.5, 0.5), a quotient and a product, cosh/sinh of 0.5, and atanh(0.5). These show that the sequencing converges, and in particular that the hyperbolic repeat indices are present.

All-zero operands expose the accumulated angle table and the zero-sign tie rule. Separate tests cover a start issued mid-run, holding the result after `done`, and the 2'b11 code.

// File: rtl/cordic_engine.sv
module cordic_engine #(
  parameter int STEPS = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               vectoring,
  input  logic [1:0]         coord,
  input  logic signed [15:0] x_in,
  input  logic signed [15:0] y_in,
  input  logic signed [15:0] z_in,
  output logic               busy,
  output logic               done,
  output logic signed [15:0] x_out,
  output logic signed [15:0] y_out,
  output logic signed [15:0] z_out
);
  localparam int W  = 16;
  localparam int CW = $clog2(STEPS + 2);
  localparam logic [1:0] C_LIN = 2'b01;
  localparam logic [1:0] C_HYP = 2'b10;

  logic [1:0]          sys_q;
  logic                vec_q;
  logic [CW-1:0]       k;
  logic signed [W-1:0] x, y, z;
  logic [3:0]          sh;
  logic signed [W-1:0] ang, xs, ys, x_n, y_n, z_n;
  logic                hyp, lin, dpos, last;

  function automatic logic signed [W-1:0] circ_ang(input logic [3:0] i);
    case (i)
      4'd0:    return 16'sd12868;
      4'd1:    return 16'sd7596;
      4'd2:    return 16'sd4014;
      4'd3:    return 16'sd2037;
      4'd4:    return 16'sd1023;
      4'd5:    return 16'sd512;
      4'd6:    return 16'sd256;
      4'd7:    return 16'sd128;
      4'd8:    return 16'sd64;
      4'd9:    return 16'sd32;
      4'd10:   return 16'sd16;
      4'd11:   return 16'sd8;
      4'd12:   return 16'sd4;
      4'd13:   return 16'sd2;
      4'd14:   return 16'sd1;
      default: return 16'sd0;
    endcase
  endfunction

  function automatic logic signed [W-1:0] hyp_ang(input logic [3:0] i);
    case (i)
      4'd1:    return 16'sd9000;
      4'd2:    return 16'sd4185;
      4'd3:    return 16'sd2059;
      4'd4:    return 16'sd1025;
      4'd5:    return 16'sd512;
      4'd6:    return 16'sd256;
      4'd7:    return 16'sd128;
      4'd8:    return 16'sd64;
      4'd9:    return 16'sd32;
      4'd10:   return 16'sd16;
      4'd11:   return 16'sd8;
      4'd12:   return 16'sd4;
      4'd13:   return 16'sd2;
      4'd14:   return 16'sd1;
      default: return 16'sd0;
    endcase
  endfunction

  assign hyp = (sys_q == C_HYP);
  assign lin = (sys_q == C_LIN);

  // hyperbolic: k=0..3 -> 1..4, k=4..STEPS-1 -> 4..STEPS-1, k=STEPS -> STEPS-1
  always_comb begin
    if (!hyp)                   sh = 4'(k);
    else if (k < CW'(4))        sh = 4'(k) + 4'd1;
    else if (k == CW'(STEPS))   sh = 4'(STEPS - 1);
    else                        sh = 4'(k);
  end

  assign last = hyp ? (k == CW'(STEPS)) : (k == CW'(STEPS - 1));
  assign dpos = vec_q ? y[W-1] : ~z[W-1];
  assign ang  = lin ? (16'sh4000 >>> sh) : (hyp ? hyp_ang(sh) : circ_ang(sh));
  assign xs   = x >>> sh;
  assign ys   = y >>> sh;
  assign x_n  = lin ? x : ((dpos ^ hyp) ? x - ys : x + ys);
  assign y_n  = dpos ? y + xs : y - xs;
  assign z_n  = dpos ? z - ang : z + ang;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      k     <= '0;
      sys_q <= 2'b00;
      vec_q <= 1'b0;
      x     <= '0;
      y     <= '0;
      z     <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        busy  <= 1'b1;
        k     <= '0;
        sys_q <= (coord == 2'b11) ? 2'b00 : coord;
        vec_q <= vectoring;
        x     <= x_in;
        y     <= y_in;
        z     <= z_in;
      end else if (busy) begin
        x <= x_n;
        y <= y_n;
        z <= z_n;
        k <= k + CW'(1);
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign x_out = x;
  assign y_out = y;
  assign z_out = z;

  a_r2_start_to_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r3_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r10_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || ($stable(sys_q) && $stable(vec_q))));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(x_out) && $stable(y_out) && $stable(z_out)));
endmodule

// File: tb/tb_cordic_engine.sv
`timescale 1ns/1ps
module tb_cordic_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic vectoring = 1'b0;
  logic [1:0] coord = 2'b00;
  logic signed [15:0] x_in = '0, y_in = '0, z_in = '0;
  logic busy, done;
  logic signed [15:0] x_out, y_out, z_out;

  cordic_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vectoring(vectoring), .coord(coord),
    .x_in(x_in), .y_in(y_in), .z_in(z_in),
    .busy(busy), .done(done), .x_out(x_out), .y_out(y_out), .z_out(z_out)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int done_seen = 0;
  logic [47:0] exp_q[$];
  int          c0_q[$];
  int          lat_q[$];
  string       tag_q[$];
  string       ltag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic int angc(input logic [1:0] c, input int i);
    real t, r;
    t = 1.0 / real'(1 << i);
    if (c == 2'b01) return 16384 >> i;
    if (c == 2'b10) r = 0.5 * $ln((1.0 + t) / (1.0 - t));
    else            r = $atan(t);
    return $rtoi(r * 16384.0 + 0.5);
  endfunction

  function automatic void step(inout logic signed [15:0] x, inout logic signed [15:0] y,
                               inout logic signed [15:0] z, input logic [1:0] c,
                               input logic vec, input int i);
    logic signed [15:0] xs, ys, a, nx, ny, nz;
    logic dp;
    xs = x >>> i;
    ys = y >>> i;
    a  = 16'(angc(c, i));
    dp = vec ? (y < 0) : (z >= 0);
    if (c == 2'b01)      nx = x;
    else if (c == 2'b10) nx = dp ? x + ys : x - ys;
    else                 nx = dp ? x - ys : x + ys;
    ny = dp ? y + xs : y - xs;
    nz = dp ? z - a : z + a;
    x = nx; y = ny; z = nz;
  endfunction

  function automatic logic [47:0] model(input logic signed [15:0] xi, input logic signed [15:0] yi,
                                        input logic signed [15:0] zi, input logic vec,
                                        input logic [1:0] craw);
    logic signed [15:0] x, y, z;
    logic [1:0] c;
    c = (craw == 2'b11) ? 2'b00 : craw;
    x = xi; y = yi; z = zi;
    if (c == 2'b10) begin
      for (int i = 1; i <= 13; i++) begin
        step(x, y, z, c, vec, i);
        if (i == 4 || i == 13) step(x, y, z, c, vec, i);
      end
    end else begin
      for (int i = 0; i <= 13; i++) step(x, y, z, c, vec, i);
    end
    return {x, y, z};
  endfunction

  always @(negedge clk) begin
    if (rst_n && done) begin
      done_seen++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected done", 1, 0);
      end else begin
        logic [47:0] e;
        int c0, lat;
        string tg, lt;
        e = exp_q.pop_front(); c0 = c0_q.pop_front(); lat = lat_q.pop_front();
        tg = tag_q.pop_front(); lt = ltag_q.pop_front();
        checks++;
        if ({x_out, y_out, z_out} !== e) begin
          fails++;
          $display("FAIL %s result actual=%h expected=%h", tg, {x_out, y_out, z_out}, e);
        end
        chk(cyc - c0 == lat, lt, "done latency", cyc - c0, lat);
      end
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy || exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic issue(input int xv, input int yv, input int zv, input logic vec,
                       input logic [1:0] c, input string tag);
    wait_idle();
    x_in = 16'(xv); y_in = 16'(yv); z_in = 16'(zv);
    vectoring = vec; coord = c; start = 1'b1;
    exp_q.push_back(model(16'(xv), 16'(yv), 16'(zv), vec, c));
    c0_q.push_back(cyc);
    lat_q.push_back((c == 2'b10) ? 16 : 15);
    tag_q.push_back(tag);
    ltag_q.push_back((c == 2'b10) ? "R7" : "R3");
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic near(input logic signed [15:0] act, input int expv, input int tol, input string tag);
    int d;
    d = int'(act) - expv;
    if (d < 0) d = -d;
    chk(d <= tol, tag, "accuracy", act, expv);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [47:0] held;
    int ds;
    repeat (3) @(negedge clk);
    chk(!busy && !done && x_out == 0 && y_out == 0 && z_out == 0, "R1", "reset state",
        {busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1", "idle after reset", {busy, done}, 0);

    // R2: busy follows accept
    @(negedge clk);
    x_in = 16'sd100; y_in = 0; z_in = 0; vectoring = 0; coord = 2'b00; start = 1'b1;
    exp_q.push_back(model(16'sd100, 0, 0, 1'b0, 2'b00));
    c0_q.push_back(cyc); lat_q.push_back(15); tag_q.push_back("R2"); ltag_q.push_back("R3");
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R2", "busy after start", busy, 1);

    issue(9949, 0, 8579, 1'b0, 2'b00, "R4");
    wait_idle();
    near(x_out, 14189, 40, "R4"); near(y_out, 8192, 40, "R4");

    issue(8192, 8192, 0, 1'b1, 2'b00, "R5");
    wait_idle();
    near(z_out, 12868, 40, "R5"); near(x_out, 19079, 40, "R5");

    issue(8192, 0, 8192, 1'b0, 2'b01, "R6");
    wait_idle();
    near(y_out, 4096, 8, "R6");
    chk(x_out == 16'sd8192, "R6", "x unchanged", x_out, 8192);
    issue(8192, 4096, 0, 1'b1, 2'b01, "R6");
    wait_idle();
    near(z_out, 8192, 8, "R6");

    issue(19784, 0, 8192, 1'b0, 2'b10, "R7");
    wait_idle();
    near(x_out, 18475, 40, "R7"); near(y_out, 8537, 40, "R7");
    issue(16384, 8192, 0, 1'b1, 2'b10, "R7");
    wait_idle();
    near(z_out, 9000, 40, "R7");

    issue(8192, 0, 0, 1'b0, 2'b00, "R8");
    issue(8192, 0, 0, 1'b1, 2'b00, "R8");
    issue(8192, 0, 0, 1'b1, 2'b10, "R8");

    issue(0, 0, 0, 1'b0, 2'b00, "R9");
    issue(0, 0, 0, 1'b0, 2'b01, "R9");
    issue(0, 0, 0, 1'b0, 2'b10, "R9");

    for (int n = 0; n < 6; n++)
      issue($urandom_range(16000) - 8000, $urandom_range(16000) - 8000,
            $urandom_range(16000) - 8000, n[0], 2'b11, "R12");

    for (int n = 0; n < 48; n++) begin
      logic [1:0] c;
      c = 2'(n % 3);
      issue($urandom_range(16000) - 8000, $urandom_range(16000) - 8000,
            $urandom_range(16000) - 8000, n[2],
            c, (c == 2'b00) ? (n[2] ? "R5" : "R4") : ((c == 2'b01) ? "R6" : "R7"));
    end

    // R10: start while busy ignored
    wait_idle();
    ds = done_seen;
    issue(6000, -3000, 4000, 1'b0, 2'b00, "R10");
    repeat (3) @(negedge clk);
    x_in = 16'sd1234; y_in = 16'sd555; z_in = -16'sd999; coord = 2'b10; vectoring = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (20) @(negedge clk);
    chk(done_seen - ds == 1, "R10", "done count", done_seen - ds, 1);

    // R11: hold after done
    issue(-5000, 7000, -2000, 1'b1, 2'b00, "R11");
    wait_idle();
    held = {x_out, y_out, z_out};
    chk(!done, "R11", "done one cycle", done, 0);
    x_in = 16'sd77; y_in = 16'sd88; z_in = 16'sd99;
    repeat (8) @(negedge clk);
    chk({x_out, y_out, z_out} == held, "R11", "outputs held", {x_out, y_out, z_out}, held);

    wait_idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule